// File: doc/BRIEF.md
# Wake Event Power Management Register

This block is a single 32-bit control and status register that gathers wake events for a network device. It turns them into a power-management event pin and a sticky interrupt flag. Energy-detect activity from two ports is latched into status bits that software clears by writing ones. Those bits cannot be cleared while the activity is still present. Each wake source has its own enable. An enabled event always raises the interrupt flag. It reaches the event pin only when a global pin enable is also set. The pin can be driven as a level that follows the interrupt flag, or as a fixed-width pulse.

The same register also holds a self-clearing reset bit for an internal virtual PHY. Writing 1 raises the reset output. The bit drops by itself once the PHY reports that its reset is done. While the bit is set, writes to it are ignored. The register can be read at any time, including while the device is not ready. Its lowest bit reports the device-ready input.

Top module: `wake_pm_reg`

## Requirements
- R1: After reset, every stored field is 0: the register reads `dev_ready` in bit 0 and zero elsewhere, and `pme_out`, `irq_flag` and `vphy_rst` are low.
- R2: When `reg_addr` equals the register offset (default 0x084), `reg_rdata` returns the register with bits 31:18, 13:11 and 8:3 reading 0 and bit 0 showing `dev_ready` combinationally. Any other address reads 0.
- R3: An active `ed_evt[0]` or `ed_evt[1]` sets status bit 16 or 17 respectively at the next clock edge.
- R4: Writing 1 to bit 16 or 17 clears that status bit only if its `ed_evt` input is low in the same cycle. Otherwise the bit stays 1.
- R5: Bits 14 and 15 (port 1 and port 2 energy-detect enables), bit 9 (wake-on-LAN enable), bit 1 (pin enable) and bit 2 (pulse mode) are read/write. A write to any other address changes nothing.
- R6: `irq_flag` is set at the next edge when an event arrives whose enable is set, regardless of the pin enable. An event whose enable is clear does not set it.
- R7: `irq_flag` stays set until `irq_clr` is pulsed. A new enabled event in the same cycle as `irq_clr` wins, and the flag stays set.
- R8: With bit 2 at 0, `pme_out` equals the pin enable ANDed with `irq_flag`.
- R9: With bit 2 at 1 and the pin enable set, an enabled event makes `pme_out` high for exactly PULSE_W (default 16) cycles, starting after the next edge. A further event restarts the count.
- R10: Writing 1 to bit 10 raises `vphy_rst` at the next edge. While it is high, every write to bit 10 is ignored.
- R11: `vphy_rst` clears at the edge where `vphy_done` is sampled while it is high. It is therefore high for at least one cycle, and `vphy_done` has no effect while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| ed_evt | input | 2 | Energy-detect activity, bit 0 = port 1, bit 1 = port 2 |
| wol_evt | input | 1 | Wake-on-LAN event |
| irq_clr | input | 1 | Clears the interrupt flag |
| vphy_done | input | 1 | Virtual PHY has left reset |
| dev_ready | input | 1 | Device ready indication |
| pme_out | output | 1 | Power-management event pin |
| irq_flag | output | 1 | Sticky wake interrupt flag |
| vphy_rst | output | 1 | Virtual PHY reset |

## Verification
The assertions watch four rules on every cycle:
- a present energy-detect event always leaves its status bit set;
- an enabled event always sets the interrupt flag;
- the pin stays low while the pin enable is clear;
- the virtual PHY reset moves only on a write of 1 while low, or on a sampled done while high.

The bench's scenarios are needed for the rest:
- the exact width of the pulse and its restart;
- the level mode following the flag;
- the read layout and address decode;
- the precedence of a new event over `irq_clr`.

A cycle model in the bench covers all of these under random traffic.

// File: rtl/wake_pm_reg.sv
module wake_pm_reg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h084,
  parameter int PULSE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        ed_evt,
  input  logic              wol_evt,
  input  logic              irq_clr,
  input  logic              vphy_done,
  input  logic              dev_ready,
  output logic              pme_out,
  output logic              irq_flag,
  output logic              vphy_rst
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [1:0]    ed_sts, ed_en;
  logic          wol_en, pin_en, pulse_mode;
  logic [CW-1:0] pulse_cnt;
  logic          sel, hit, trig;
  logic          unused_wbits;

  assign sel  = (reg_addr == REG_OFFSET);
  assign hit  = reg_wr && sel;
  assign trig = (|(ed_evt & ed_en)) | (wol_evt & wol_en);
  assign unused_wbits = ^{reg_wdata[31:18], reg_wdata[13:11], reg_wdata[8:3], reg_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ed_sts     <= '0;
      ed_en      <= '0;
      wol_en     <= 1'b0;
      pin_en     <= 1'b0;
      pulse_mode <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++)
        ed_sts[i] <= ed_evt[i] | (ed_sts[i] & ~(hit & reg_wdata[16+i]));
      if (hit) begin
        ed_en      <= reg_wdata[15:14];
        wol_en     <= reg_wdata[9];
        pulse_mode <= reg_wdata[2];
        pin_en     <= reg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      irq_flag <= trig | (irq_flag & ~irq_clr);
      if (trig)
        pulse_cnt <= CW'(PULSE_W);
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vphy_rst <= 1'b0;
    else if (vphy_rst) begin
      if (vphy_done) vphy_rst <= 1'b0;
    end else if (hit && reg_wdata[10])
      vphy_rst <= 1'b1;
  end

  assign pme_out = pin_en & (pulse_mode ? (pulse_cnt != '0) : irq_flag);

  assign reg_rdata = sel ? {14'd0, ed_sts, ed_en, 3'd0, vphy_rst, wol_en, 6'd0,
                            pulse_mode, pin_en, dev_ready} : 32'd0;
endmodule

// File: rtl/wake_pm_reg_chk.sv
module wake_pm_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hit,
  input logic [31:0] reg_wdata,
  input logic [1:0] ed_evt,
  input logic       wol_evt,
  input logic [1:0] ed_sts,
  input logic [1:0] ed_en,
  input logic       wol_en,
  input logic       pin_en,
  input logic       vphy_done,
  input logic       pme_out,
  input logic       irq_flag,
  input logic       vphy_rst
);
  AST_STS_STICKY_P1: assert property (@(posedge clk) disable iff (!rst_n) ed_evt[0] |=> ed_sts[0]); // R4
  AST_STS_STICKY_P2: assert property (@(posedge clk) disable iff (!rst_n) ed_evt[1] |=> ed_sts[1]); // R3
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ed_evt & ed_en)) || (wol_evt && wol_en)) |=> irq_flag); // R6
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n) !pin_en |-> !pme_out); // R8
  AST_VPHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vphy_rst && !vphy_done) |=> vphy_rst); // R10
  AST_VPHY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (vphy_rst && vphy_done) |=> !vphy_rst); // R11
  AST_VPHY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!vphy_rst && !(hit && reg_wdata[10])) |=> !vphy_rst); // R11
endmodule

bind wake_pm_reg wake_pm_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .reg_wdata(reg_wdata), .ed_evt(ed_evt),
  .wol_evt(wol_evt), .ed_sts(ed_sts), .ed_en(ed_en), .wol_en(wol_en), .pin_en(pin_en),
  .vphy_done(vphy_done), .pme_out(pme_out), .irq_flag(irq_flag), .vphy_rst(vphy_rst)
);

// File: tb/tb_wake_pm_reg.sv
module tb_wake_pm_reg;
  localparam logic [11:0] OFS = 12'h084;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, wol_evt = 1'b0, irq_clr = 1'b0, vphy_done = 1'b0, dev_ready = 1'b0;
  logic [11:0] reg_addr = OFS;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] ed_evt = '0;
  logic pme_out, irq_flag, vphy_rst;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [1:0] m_sts, m_en;
  logic m_wol, m_pin, m_mode, m_vphy, m_irq;
  int m_cnt;

  always #5 clk = ~clk;

  wake_pm_reg dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .ed_evt,
    .wol_evt, .irq_clr, .vphy_done, .dev_ready, .pme_out, .irq_flag, .vphy_rst);

  function automatic logic [31:0] exp_word(logic rdy);
    return {14'd0, m_sts, m_en, 3'd0, m_vphy, m_wol, 6'd0, m_mode, m_pin, rdy};
  endfunction

  function automatic logic exp_pme();
    return m_pin & (m_mode ? (m_cnt != 0) : m_irq);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sts = '0; m_en = '0; m_wol = 0; m_pin = 0; m_mode = 0; m_vphy = 0; m_irq = 0; m_cnt = 0;
  endtask

  task automatic compare_all();
    chk(reg_rdata === exp_word(dev_ready), "R2/R3/R4/R5", reg_rdata, exp_word(dev_ready));
    chk(pme_out === exp_pme(), "R8/R9", {31'd0, pme_out}, {31'd0, exp_pme()});
    chk(irq_flag === m_irq, "R6/R7", {31'd0, irq_flag}, {31'd0, m_irq});
    chk(vphy_rst === m_vphy, "R10/R11", {31'd0, vphy_rst}, {31'd0, m_vphy});
  endtask

  task automatic step(logic wr, logic [11:0] a, logic [31:0] wd, logic [1:0] ev,
                      logic wl, logic clr, logic dn);
    logic hit, trig;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; ed_evt = ev; wol_evt = wl;
    irq_clr = clr; vphy_done = dn;
    hit = wr && (a == OFS);
    trig = (|(ev & m_en)) | (wl & m_wol);
    for (int i = 0; i < 2; i++) m_sts[i] = ev[i] | (m_sts[i] & ~(hit & wd[16+i]));
    m_irq = trig | (m_irq & ~clr);
    m_cnt = trig ? PW : (m_cnt != 0 ? m_cnt - 1 : 0);
    if (m_vphy) begin
      if (dn) m_vphy = 0;
    end else if (hit && wd[10]) m_vphy = 1;
    if (hit) begin
      m_en = wd[15:14]; m_wol = wd[9]; m_mode = wd[2]; m_pin = wd[1];
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_addr = OFS; irq_clr = 1'b0; wol_evt = 1'b0; vphy_done = 1'b0;
    #1;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd4242));
    model_reset();
    dev_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(reg_rdata === 32'd0 && !pme_out && !irq_flag && !vphy_rst, "R1", reg_rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    #1; dev_ready = 1'b1; #1;
    chk(reg_rdata === 32'h1, "R1 ready bit", reg_rdata, 32'h1);
    reg_addr = 12'h080; #1;
    chk(reg_rdata === 32'd0, "R2 other address", reg_rdata, 32'd0);
    reg_addr = OFS;

    // R5 write to wrong address ignored, then real write of enables
    step(1, 12'h088, 32'hFFFF_FFFF, 2'b00, 0, 0, 0);
    chk(reg_rdata === 32'h1, "R5 wrong address", reg_rdata, 32'h1);
    step(1, OFS, 32'hFFFF_FFFF & ~32'h0000_0400, 2'b00, 0, 0, 0);
    chk(reg_rdata === 32'h0000_C207, "R5 enables readback", reg_rdata, 32'h0000_C207);

    // R6 irq without pin enable; R8 pin stays low
    step(1, OFS, 32'h0000_C200, 2'b00, 0, 0, 0);
    step(0, OFS, 0, 2'b00, 1, 0, 0);
    chk(irq_flag === 1'b1 && pme_out === 1'b0, "R6 irq without pin", {30'd0, irq_flag, pme_out}, 32'h2);
    step(0, OFS, 0, 2'b00, 0, 1, 0);
    chk(irq_flag === 1'b0, "R7 clear", {31'd0, irq_flag}, 32'd0);
    step(0, OFS, 0, 2'b10, 0, 1, 0);
    chk(irq_flag === 1'b1, "R7 event beats clear", {31'd0, irq_flag}, 32'd1);
    step(1, OFS, 32'h0000_0000, 2'b11, 0, 1, 0);
    step(0, OFS, 0, 2'b11, 0, 1, 0);
    chk(irq_flag === 1'b0, "R6 disabled events ignored", {31'd0, irq_flag}, 32'd0);

    // R3/R4 status hold while event active
    chk(reg_rdata[17:16] === 2'b11, "R3 latch", {30'd0, reg_rdata[17:16]}, 32'd3);
    step(1, OFS, 32'h0003_0000, 2'b11, 0, 0, 0);
    chk(reg_rdata[17:16] === 2'b11, "R4 blocked clear", {30'd0, reg_rdata[17:16]}, 32'd3);
    step(1, OFS, 32'h0001_0000, 2'b10, 0, 0, 0);
    chk(reg_rdata[17:16] === 2'b10, "R4 clear port 1", {30'd0, reg_rdata[17:16]}, 32'd2);
    step(1, OFS, 32'h0002_0000, 2'b00, 0, 0, 0);
    chk(reg_rdata[17:16] === 2'b00, "R4 clear port 2", {30'd0, reg_rdata[17:16]}, 32'd0);

    // R8 level mode
    step(1, OFS, 32'h0000_4002, 2'b00, 0, 0, 0);
    step(0, OFS, 0, 2'b01, 0, 0, 0);
    chk(pme_out === 1'b1, "R8 level high", {31'd0, pme_out}, 32'd1);
    step(0, OFS, 0, 2'b00, 0, 1, 0);
    chk(pme_out === 1'b0, "R8 level follows flag", {31'd0, pme_out}, 32'd0);

    // R9 pulse width and restart
    step(1, OFS, 32'h0000_4006, 2'b00, 0, 0, 0);
    step(0, OFS, 0, 2'b01, 0, 0, 0);
    pulses = pme_out ? 1 : 0;
    for (int k = 0; k < PW + 4; k++) begin
      step(0, OFS, 0, 2'b00, 0, 0, 0);
      if (pme_out) pulses++;
    end
    chk(pulses == PW, "R9 pulse width", pulses, PW);
    step(0, OFS, 0, 2'b01, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(0, OFS, 0, 2'b00, 0, 0, 0);
    step(0, OFS, 0, 2'b01, 0, 0, 0);
    pulses = 1;
    for (int k = 0; k < PW + 4; k++) begin
      step(0, OFS, 0, 2'b00, 0, 0, 0);
      if (pme_out) pulses++;
    end
    chk(pulses == PW, "R9 restart", pulses, PW);

    // R10/R11 virtual PHY reset
    step(0, OFS, 0, 2'b00, 0, 0, 1);
    chk(vphy_rst === 1'b0, "R11 done while low", {31'd0, vphy_rst}, 32'd0);
    step(1, OFS, 32'h0000_0400, 2'b00, 0, 0, 0);
    chk(vphy_rst === 1'b1 && reg_rdata[10] === 1'b1, "R10 set", {31'd0, vphy_rst}, 32'd1);
    step(1, OFS, 32'h0000_0000, 2'b00, 0, 0, 0);
    chk(vphy_rst === 1'b1, "R10 write ignored", {31'd0, vphy_rst}, 32'd1);
    step(0, OFS, 0, 2'b00, 0, 0, 1);
    chk(vphy_rst === 1'b0, "R11 release", {31'd0, vphy_rst}, 32'd0);
    step(1, OFS, 32'h0000_0400, 2'b00, 0, 0, 1);
    chk(vphy_rst === 1'b1, "R11 minimum one cycle", {31'd0, vphy_rst}, 32'd1);
    step(0, OFS, 0, 2'b00, 0, 0, 1);
    chk(vphy_rst === 1'b0, "R11 release after one", {31'd0, vphy_rst}, 32'd0);

    // random traffic against the cycle model
    for (int n = 0; n < 600; n++) begin
      logic wr, wl, clr, dn;
      logic [1:0] ev;
      logic [11:0] a;
      logic [31:0] wd;
      wr  = ($urandom % 5) == 0;
      a   = (($urandom % 8) == 0) ? 12'h090 : OFS;
      wd  = $urandom;
      ev  = {($urandom % 7) == 0, ($urandom % 7) == 0};
      wl  = ($urandom % 9) == 0;
      clr = ($urandom % 6) == 0;
      dn  = ($urandom % 4) == 0;
      if (($urandom % 10) == 0) dev_ready = ~dev_ready;
      step(wr, a, wd, ev, wl, clr, dn);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule